// File: doc/BRIEF.md
# Wrap-Around Burst Read Sequencer

This block turns one read request into a burst of data words, one word per rising clock edge. The request gives a start address and a choice of a short burst (4 words) or a long burst (8 words). In the same cycle the caller presents the whole aligned block of words on a wide input. The sequencer captures that block into a shift register, rotated so that the requested word is in front.

It then delivers the requested word first. The later words of the block follow in rising offset order. After the highest offset the sequence wraps to offset zero of the same block and stops just before the requested word. This order lets a cache refill return the critical word in the first cycle of the burst.

A valid flag marks each delivered word and a last flag marks the final one. The address of the word on the output is given beside the data. Its upper bits stay at the values of the request.

Top module: `wrap_burst_seq`

## Requirements
- R1: While reset is held and after its release with no request, `valid_o` and `last_o` are 0 and `data_o` is 0.
- R2: A start strobe sampled while idle is accepted. After that edge, `valid_o` is 1, `addr_o` equals the requested address and `data_o` holds the block word at the requested offset. Block word k sits at `block_i[k*DATA_W +: DATA_W]`.
- R3: At each later edge the offset advances by one, modulo the burst length, and `data_o` shows the block word at that offset.
- R4: `len8_i`=0 selects a burst of 4 words: the offset is `addr_i[1:0]` and block words 0 to 3 are used. `len8_i`=1 selects a burst of 8 words: the offset is `addr_i[2:0]` and block words 0 to 7 are used.
- R5: `last_o` is 1 exactly with the final word of the burst, which is the word one offset below the requested one, cyclically.
- R6: In the cycle after the final word `valid_o` is 0. Whenever `valid_o` is 0, `data_o` is 0.
- R7: While a burst is active, up to and including its last-word cycle, a start strobe and any change of `addr_i`, `len8_i` or `block_i` have no effect on the burst's words, addresses, length or end.
- R8: During a burst, all bits of `addr_o` above the offset field equal those of the requested address.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; all sampling and updates happen on the rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| start_i | input | 1 | Request strobe, taken only while idle |
| addr_i | input | ADDR_W | Word address of the requested word |
| len8_i | input | 1 | Burst length select: 0 gives 4 words, 1 gives 8 words |
| block_i | input | LONG_LEN*DATA_W | Aligned block, word k at bits k*DATA_W upward |
| data_o | output | DATA_W | Current burst word |
| valid_o | output | 1 | A burst word is on `data_o` |
| last_o | output | 1 | The current word is the final word of the burst |
| addr_o | output | ADDR_W | Address of the word on `data_o` |

## Verification
The case that needs care is a start strobe arriving in the same cycle that the final word is delivered. In that cycle the burst-end logic and the request-accept logic both act at one edge. The bench provokes this by raising the strobe, with a different address and a different block, at the middle of a long burst and again at its last-word cycle. It judges the result by checking two things: every word and address match the original request, and `valid_o` falls in the following cycle instead of starting a new burst.

// File: rtl/wbs_pkg.sv
package wbs_pkg;
  // Address of the next word: the offset field wraps inside the aligned
  // block and every bit above the field is kept. len must be a power of two.
  function automatic int unsigned wrap_step(int unsigned a, int unsigned len);
    return (a & ~(len - 1)) | ((a + 1) & (len - 1));
  endfunction

  // Block slot that lands in shift position pos for a burst starting at off.
  function automatic int unsigned slot_of(int unsigned off, int unsigned pos,
                                          int unsigned len);
    return (off + pos) & (len - 1);
  endfunction
endpackage

// File: rtl/wbs_ctrl.sv
module wbs_ctrl #(
  parameter int ADDR_W    = 8,
  parameter int SHORT_LEN = 4,
  parameter int LONG_LEN  = 8,
  localparam int LOG_W    = $clog2(LONG_LEN)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [LOG_W:0]    len_sel_i,
  output logic              accept_o,
  output logic              busy_o,
  output logic              last_o,
  output logic [ADDR_W-1:0] addr_o
);
  import wbs_pkg::*;

  logic              busy_q;
  logic [LOG_W:0]    rem_q;
  logic [LOG_W:0]    len_q;
  logic [ADDR_W-1:0] addr_q;

  assign accept_o = start_i && !busy_q;
  assign busy_o   = busy_q;
  assign last_o   = busy_q && (rem_q == '0);
  assign addr_o   = addr_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      rem_q  <= '0;
      len_q  <= '0;
      addr_q <= '0;
    end else if (accept_o) begin
      busy_q <= 1'b1;
      rem_q  <= len_sel_i - 1'b1;
      len_q  <= len_sel_i;
      addr_q <= addr_i;
    end else if (busy_q) begin
      if (rem_q == '0) begin
        busy_q <= 1'b0;
      end else begin
        rem_q  <= rem_q - 1'b1;
        addr_q <= ADDR_W'(wrap_step(int'(addr_q), int'(len_q)));
      end
    end
  end
endmodule

// File: rtl/wbs_shreg.sv
module wbs_shreg #(
  parameter int DATA_W = 16,
  parameter int DEPTH  = 8,
  localparam int LOG_W = $clog2(DEPTH)
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    load_i,
  input  logic                    shift_i,
  input  logic [LOG_W-1:0]        off_i,
  input  logic [LOG_W:0]          len_i,
  input  logic [DEPTH*DATA_W-1:0] block_i,
  output logic [DATA_W-1:0]       data_o
);
  import wbs_pkg::*;

  logic [DATA_W-1:0] word_q [DEPTH];

  for (genvar g = 0; g < DEPTH; g++) begin : g_pos
    logic [LOG_W-1:0]  slot_w;
    logic [DATA_W-1:0] fill_w;
    logic [DATA_W-1:0] next_w;

    assign slot_w = LOG_W'(slot_of(int'(off_i), g, int'(len_i)));
    assign fill_w = (g < int'(len_i)) ? block_i[slot_w*DATA_W +: DATA_W] : '0;

    if (g == DEPTH - 1) begin : g_top
      assign next_w = '0;
    end else begin : g_mid
      assign next_w = word_q[g+1];
    end

    always_ff @(posedge clk) begin
      if (!rst_n)       word_q[g] <= '0;
      else if (load_i)  word_q[g] <= fill_w;
      else if (shift_i) word_q[g] <= next_w;
    end
  end

  assign data_o = word_q[0];
endmodule

// File: rtl/wrap_burst_seq.sv
module wrap_burst_seq #(
  parameter int DATA_W    = 16,
  parameter int ADDR_W    = 8,
  parameter int SHORT_LEN = 4,
  parameter int LONG_LEN  = 8,
  localparam int LOG_W    = $clog2(LONG_LEN)
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       start_i,
  input  logic [ADDR_W-1:0]          addr_i,
  input  logic                       len8_i,
  input  logic [LONG_LEN*DATA_W-1:0] block_i,
  output logic [DATA_W-1:0]          data_o,
  output logic                       valid_o,
  output logic                       last_o,
  output logic [ADDR_W-1:0]          addr_o
);
  logic [LOG_W:0] len_sel_w;
  logic           accept_w;
  logic           busy_w;
  logic           done_w;

  assign len_sel_w = len8_i ? (LOG_W+1)'(LONG_LEN) : (LOG_W+1)'(SHORT_LEN);

  wbs_ctrl #(
    .ADDR_W(ADDR_W), .SHORT_LEN(SHORT_LEN), .LONG_LEN(LONG_LEN)
  ) ctrl_i (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .addr_i(addr_i),
    .len_sel_i(len_sel_w), .accept_o(accept_w), .busy_o(busy_w),
    .last_o(done_w), .addr_o(addr_o)
  );

  wbs_shreg #(
    .DATA_W(DATA_W), .DEPTH(LONG_LEN)
  ) shreg_i (
    .clk(clk), .rst_n(rst_n), .load_i(accept_w), .shift_i(busy_w),
    .off_i(addr_i[LOG_W-1:0]), .len_i(len_sel_w), .block_i(block_i),
    .data_o(data_o)
  );

  assign valid_o = busy_w;
  assign last_o  = done_w;
endmodule

// File: rtl/wrap_burst_seq_chk.sv
module wrap_burst_seq_chk #(
  parameter int DATA_W = 16,
  parameter int ADDR_W = 8,
  parameter int LOG_W  = 3
) (
  input logic              clk,
  input logic              rst_n,
  input logic [ADDR_W-1:0] addr_i,
  input logic [DATA_W-1:0] data_o,
  input logic              valid_o,
  input logic              last_o,
  input logic [ADDR_W-1:0] addr_o,
  input logic              accept_w
);
  a_r2_first_addr: assert property (@(posedge clk) disable iff (!rst_n)
    accept_w |=> valid_o && (addr_o == $past(addr_i)));
  a_r5_last_in_burst: assert property (@(posedge clk) disable iff (!rst_n)
    last_o |-> valid_o);
  a_r6_drop_after_last: assert property (@(posedge clk) disable iff (!rst_n)
    last_o |=> !valid_o);
  a_r6_idle_zero: assert property (@(posedge clk) disable iff (!rst_n)
    !valid_o |-> (data_o == '0));
  a_r7_no_restart: assert property (@(posedge clk) disable iff (!rst_n)
    valid_o |-> !accept_w);
  a_r7_keeps_running: assert property (@(posedge clk) disable iff (!rst_n)
    (valid_o && !last_o) |=> valid_o);
  a_r8_upper_fixed: assert property (@(posedge clk) disable iff (!rst_n)
    (valid_o && !last_o) |=> $stable(addr_o[ADDR_W-1:LOG_W]));
endmodule

bind wrap_burst_seq wrap_burst_seq_chk #(
  .DATA_W(DATA_W), .ADDR_W(ADDR_W), .LOG_W(LOG_W)
) chk_i (
  .clk(clk), .rst_n(rst_n), .addr_i(addr_i), .data_o(data_o),
  .valid_o(valid_o), .last_o(last_o), .addr_o(addr_o), .accept_w(accept_w)
);

// File: tb/wrap_burst_seq_tb_top.sv
module wrap_burst_seq_tb_top;
  localparam int DW = 16;
  localparam int AW = 8;
  localparam int NL = 8;

  logic           clk = 1'b0;
  logic           rst_n = 1'b0;
  logic           start_i = 1'b0;
  logic [AW-1:0]  addr_i = '0;
  logic           len8_i = 1'b0;
  logic [NL*DW-1:0] block_i = '0;
  logic [DW-1:0]  data_o;
  logic           valid_o, last_o;
  logic [AW-1:0]  addr_o;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 0;

  always #5 clk = ~clk;

  wrap_burst_seq dut_i (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .addr_i(addr_i),
    .len8_i(len8_i), .block_i(block_i), .data_o(data_o),
    .valid_o(valid_o), .last_o(last_o), .addr_o(addr_o)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [NL*DW-1:0] mk_block(input int seed);
    logic [NL*DW-1:0] b;
    for (int k = 0; k < NL; k++) b[k*DW +: DW] = DW'((seed << 8) | (k + 1));
    return b;
  endfunction

  // One burst; poke raises a foreign request mid-burst and at the last word.
  task automatic run_burst(input logic [AW-1:0] a, input bit l8, input int seed,
                           input bit poke);
    int n   = l8 ? 8 : 4;
    int off = int'(a) & (n - 1);
    @(negedge clk);
    start_i = 1'b1; addr_i = a; len8_i = l8; block_i = mk_block(seed);
    @(negedge clk);
    start_i = 1'b0;
    for (int i = 0; i < n; i++) begin
      int slot = (off + i) & (n - 1);
      int ea   = (int'(a) & ~(n - 1)) | slot;
      int ed   = (seed << 8) | (slot + 1);
      chk(valid_o === 1'b1, i == 0 ? "R2 valid" : "R4 valid", int'(valid_o), 1);
      chk(data_o === DW'(ed), i == 0 ? "R2 first word" : "R3 word order",
          int'(data_o), ed);
      chk(addr_o === AW'(ea), "R8 address", int'(addr_o), ea);
      chk(last_o === (i == n - 1), "R5 last flag", int'(last_o), int'(i == n - 1));
      if (poke) begin
        start_i = (i == 2) || (i == n - 1);
        addr_i  = ~a;
        len8_i  = ~l8;
        block_i = mk_block(seed + 1);
      end
      @(negedge clk);
    end
    start_i = 1'b0;
    chk(valid_o === 1'b0, poke ? "R7 no restart" : "R6 valid drop", int'(valid_o), 0);
    chk(data_o === '0, "R6 idle data", int'(data_o), 0);
    chk(last_o === 1'b0, "R6 idle last", int'(last_o), 0);
  endtask

  task automatic t_reset();
    @(negedge clk);
    chk(valid_o === 1'b0, "R1 valid", int'(valid_o), 0);
    chk(last_o === 1'b0, "R1 last", int'(last_o), 0);
    chk(data_o === '0, "R1 data", int'(data_o), 0);
    rst_n = 1'b1;
    @(negedge clk); @(negedge clk);
    chk(valid_o === 1'b0, "R1 idle after reset", int'(valid_o), 0);
  endtask

  task automatic t_short_mid();  run_burst(8'h5A, 1'b0, 8'h21, 1'b0); endtask
  task automatic t_short_top();  run_burst(8'h33, 1'b0, 8'h32, 1'b0); endtask
  task automatic t_short_bit2(); run_burst(8'h04, 1'b0, 8'h43, 1'b0); endtask
  task automatic t_long_wrap();  run_burst(8'hC5, 1'b1, 8'h54, 1'b0); endtask
  task automatic t_long_zero();  run_burst(8'h10, 1'b1, 8'h65, 1'b0); endtask
  task automatic t_ignore();     run_burst(8'h7E, 1'b1, 8'h76, 1'b1); endtask
  task automatic t_after();      run_burst(8'h81, 1'b0, 8'h17, 1'b0); endtask

  initial begin
    t_reset();
    t_short_mid();
    t_short_top();
    t_short_bit2();
    t_long_wrap();
    t_long_zero();
    t_ignore();
    t_after();
    if (!done) begin
      done = 1;
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  end

  initial begin
    #2000000;
    if (!done) begin
      done = 1;
      n_chk++; n_bad++;
      $display("FAIL watchdog actual=%0h expected=%0h", 0, 1);
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  end
endmodule